// File: doc/BRIEF.md
# Queue Pointer Controller

This block keeps a read pointer and a write pointer for each of a parameterised set of hardware queues. Software, or any agent on a simple 32-bit register bus, moves a pointer by writing an increment to a per-queue add register. It reads the pointer positions back through two status words. Each queue also holds a software-settable size, the occupancy derived from its two pointers, and two sticky error flags: overflow on the producer side and underflow on the consumer side.

Every queue owns a 0x800-byte register window, and the array of windows starts at byte offset 0x80000 of the block's address space. The queue index is taken from address bits 18:11. Both pointers are 18 bits wide and run freely, wrapping modulo 2^18. A single add moves a pointer by at most 63, so a producer that wants to advance further splits the step into several writes.

Top module: `qpc_top`

## Requirements
- R1: Queue q (q < NUM_Q) occupies the window 0x80000 + q*0x800. A write to window offset 0x0 adds to its read pointer, a write to offset 0x4 adds to its write pointer, and no other queue changes.
- R2: A read of window offset 0x8 returns the read pointer in bits 17:0 and the underflow flag in bit 31. A read of offset 0xC returns the write pointer in bits 17:0 and the overflow flag in bit 31. Bits 30:18 read as zero.
- R3: An add uses only bits 5:0 of the written data, so one add moves a pointer by 0 to 63. For example, writing 0x45 adds 5.
- R4: Both pointers wrap modulo 2^18. Adding 1 to 0x3FFFF gives 0.
- R5: Window offset 0x10 is a read/write size register that keeps bits 17:0 of the written data. Window offset 0x14 reads the occupancy, which is the write pointer minus the read pointer, modulo 2^18.
- R6: A write-pointer add of n with occupancy + n > size sets the overflow flag. Reaching exactly the size does not set it. The flag is sticky until reset, and the pointer still advances.
- R7: A read-pointer add of n with n > occupancy sets the underflow flag. Draining exactly to zero does not set it. The flag is sticky until reset, and the pointer still advances.
- R8: The following read as zero and ignore writes: addresses below 0x80000, queue indices at or above NUM_Q, and window offsets other than 0x0, 0x4, 0x8, 0xC, 0x10 and 0x14.
- R9: Read data appears on the cycle after the read strobe. It reflects the state before any write on that same cycle. It is zero on a cycle that follows no read.
- R10: After reset every pointer and flag is zero and every size equals SIZE_RST (64).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 20 | Byte address of the access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, registered, one cycle after bus_re |

## Verification
The bound checker watches every queue on every cycle for several properties. A pointer may change only after a bus write. A write pointer never moves by more than 63 in one step. Both error flags stay set once raised, and an overflow flag can only rise after a write. Read data stays zero after an idle cycle. The scenarios are needed for the rest. These are the exact address decode, the flag thresholds at the size and at zero occupancy, the masking of wide add values, the wrap of a pointer at 2^18, the old-value return when a read and a write meet on the same cycle, and silence for unmapped queues and offsets.

// File: rtl/qpc_pkg.sv
package qpc_pkg;

   // Register selected inside one queue window.
   typedef enum logic [2:0] {
      QREG_NONE,
      QREG_ADD_RD,
      QREG_ADD_WR,
      QREG_STAT_RD,
      QREG_STAT_WR,
      QREG_SIZE,
      QREG_OCC
   } qpc_reg_e;

   // Byte offsets inside a window; the add/status order is the software contract.
   localparam int OFF_ADD_RD  = 'h00;
   localparam int OFF_ADD_WR  = 'h04;
   localparam int OFF_STAT_RD = 'h08;
   localparam int OFF_STAT_WR = 'h0C;
   localparam int OFF_SIZE    = 'h10;
   localparam int OFF_OCC     = 'h14;

endpackage

// File: rtl/qpc_decode.sv
module qpc_decode
   import qpc_pkg::*;
#(
   parameter int ADDR_W    = 20,
   parameter int WIN_SHIFT = 11,
   parameter int QIDX_W    = 8,
   parameter int ARRAY_TAG = 1,
   parameter int NUM_Q     = 8,
   parameter int QSEL_W    = 3
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit,
   output logic [QSEL_W-1:0] qsel,
   output qpc_reg_e          reg_sel
);
   localparam int TAG_W = ADDR_W - WIN_SHIFT - QIDX_W;
   localparam logic [QIDX_W:0] NQ = (QIDX_W+1)'(NUM_Q);

   logic [TAG_W-1:0]     tag;
   logic [QIDX_W-1:0]    qidx;
   logic [WIN_SHIFT-1:0] off;
   logic                 q_ok;

   assign tag  = addr[ADDR_W-1 -: TAG_W];
   assign qidx = addr[WIN_SHIFT +: QIDX_W];
   assign off  = addr[WIN_SHIFT-1:0];
   assign q_ok = (tag == TAG_W'(ARRAY_TAG)) && ({1'b0, qidx} < NQ);
   assign qsel = qidx[QSEL_W-1:0];

   always_comb begin
      reg_sel = QREG_NONE;
      if (q_ok) begin
         if      (off == WIN_SHIFT'(OFF_ADD_RD))  reg_sel = QREG_ADD_RD;
         else if (off == WIN_SHIFT'(OFF_ADD_WR))  reg_sel = QREG_ADD_WR;
         else if (off == WIN_SHIFT'(OFF_STAT_RD)) reg_sel = QREG_STAT_RD;
         else if (off == WIN_SHIFT'(OFF_STAT_WR)) reg_sel = QREG_STAT_WR;
         else if (off == WIN_SHIFT'(OFF_SIZE))    reg_sel = QREG_SIZE;
         else if (off == WIN_SHIFT'(OFF_OCC))     reg_sel = QREG_OCC;
      end
   end

   assign hit = (reg_sel != QREG_NONE);

endmodule

// File: rtl/qpc_add_amt.sv
module qpc_add_amt #(
   parameter int DATA_W   = 32,
   parameter int ADD_W    = 6,
   parameter int PTR_W    = 18,
   parameter bit SATURATE = 1'b0
) (
   input  logic [DATA_W-1:0] wdata,
   output logic [PTR_W-1:0]  amt
);
   localparam int MAX_ADD = (1 << ADD_W) - 1;

   logic [ADD_W-1:0] step;

   generate
      if (SATURATE) begin : g_sat
         // Values beyond the field saturate to the largest legal step.
         assign step = (wdata > DATA_W'(MAX_ADD)) ? ADD_W'(MAX_ADD) : wdata[ADD_W-1:0];
      end else begin : g_mask
         // Bits above the field are dropped.
         logic unused_hi;
         assign unused_hi = ^wdata[DATA_W-1:ADD_W];
         assign step      = wdata[ADD_W-1:0];
      end
   endgenerate

   assign amt = {{(PTR_W-ADD_W){1'b0}}, step};

endmodule

// File: rtl/qpc_slot.sv
module qpc_slot #(
   parameter int PTR_W    = 18,
   parameter int SIZE_RST = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             add_rd_en,
   input  logic             add_wr_en,
   input  logic             size_en,
   input  logic [PTR_W-1:0] amt,
   input  logic [PTR_W-1:0] size_val,
   output logic [PTR_W-1:0] rptr,
   output logic [PTR_W-1:0] wptr,
   output logic [PTR_W-1:0] size,
   output logic [PTR_W-1:0] occ,
   output logic             ovf,
   output logic             unf
);
   logic ovf_hit, unf_hit;

   assign occ     = wptr - rptr;
   assign ovf_hit = ({1'b0, occ} + {1'b0, amt}) > {1'b0, size};
   assign unf_hit = amt > occ;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rptr <= '0;
         wptr <= '0;
         size <= PTR_W'(SIZE_RST);
         ovf  <= 1'b0;
         unf  <= 1'b0;
      end else begin
         if (add_rd_en) begin
            rptr <= rptr + amt;
            if (unf_hit) unf <= 1'b1;
         end
         if (add_wr_en) begin
            wptr <= wptr + amt;
            if (ovf_hit) ovf <= 1'b1;
         end
         if (size_en) size <= size_val;
      end
   end

endmodule

// File: rtl/qpc_rdmux.sv
module qpc_rdmux
   import qpc_pkg::*;
#(
   parameter int NUM_Q  = 8,
   parameter int PTR_W  = 18,
   parameter int DATA_W = 32,
   parameter int QSEL_W = 3
) (
   input  logic                        hit,
   input  qpc_reg_e                    reg_sel,
   input  logic [QSEL_W-1:0]           qsel,
   input  logic [NUM_Q-1:0][PTR_W-1:0] q_rptr,
   input  logic [NUM_Q-1:0][PTR_W-1:0] q_wptr,
   input  logic [NUM_Q-1:0][PTR_W-1:0] q_size,
   input  logic [NUM_Q-1:0][PTR_W-1:0] q_occ,
   input  logic [NUM_Q-1:0]            q_ovf,
   input  logic [NUM_Q-1:0]            q_unf,
   output logic [DATA_W-1:0]           word
);
   localparam int PAD_W = DATA_W - 1 - PTR_W;

   always_comb begin
      word = '0;
      if (hit) begin
         unique case (reg_sel)
            QREG_STAT_RD: word = {q_unf[qsel], {PAD_W{1'b0}}, q_rptr[qsel]};
            QREG_STAT_WR: word = {q_ovf[qsel], {PAD_W{1'b0}}, q_wptr[qsel]};
            QREG_SIZE:    word = {1'b0, {PAD_W{1'b0}}, q_size[qsel]};
            QREG_OCC:     word = {1'b0, {PAD_W{1'b0}}, q_occ[qsel]};
            default:      word = '0;
         endcase
      end
   end

endmodule

// File: rtl/qpc_top.sv
module qpc_top
   import qpc_pkg::*;
#(
   parameter int NUM_Q        = 8,
   parameter int PTR_W        = 18,
   parameter int ADD_W        = 6,
   parameter int ADDR_W       = 20,
   parameter int DATA_W       = 32,
   parameter int WIN_SHIFT    = 11,
   parameter int QIDX_W       = 8,
   parameter int ARRAY_TAG    = 1,
   parameter int SIZE_RST     = 64,
   parameter bit SATURATE_ADD = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_re,
   output logic [DATA_W-1:0] bus_rdata
);
   localparam int QSEL_W = (NUM_Q > 1) ? $clog2(NUM_Q) : 1;

   initial begin
      assert (NUM_Q >= 1 && NUM_Q <= (1 << QIDX_W)) else $fatal(1, "NUM_Q out of range");
      assert (ADDR_W > WIN_SHIFT + QIDX_W) else $fatal(1, "no room for array tag");
      assert (WIN_SHIFT >= 5) else $fatal(1, "window too small for registers");
      assert (ADD_W >= 1 && ADD_W < PTR_W) else $fatal(1, "ADD_W out of range");
      assert (PTR_W + 1 < DATA_W) else $fatal(1, "PTR_W too wide for data bus");
      assert (SIZE_RST >= 0 && SIZE_RST < (1 << PTR_W)) else $fatal(1, "SIZE_RST out of range");
   end

   logic                        hit;
   logic [QSEL_W-1:0]           qsel;
   qpc_reg_e                    reg_sel;
   logic [PTR_W-1:0]            amt;
   logic [PTR_W-1:0]            size_val;
   logic [DATA_W-1:0]           rd_word;
   logic [NUM_Q-1:0][PTR_W-1:0] q_rptr, q_wptr, q_size, q_occ;
   logic [NUM_Q-1:0]            q_ovf, q_unf;
   logic                        unused_wd_hi;

   assign size_val     = bus_wdata[PTR_W-1:0];
   assign unused_wd_hi = ^bus_wdata[DATA_W-1:PTR_W];

   qpc_decode #(
      .ADDR_W(ADDR_W), .WIN_SHIFT(WIN_SHIFT), .QIDX_W(QIDX_W),
      .ARRAY_TAG(ARRAY_TAG), .NUM_Q(NUM_Q), .QSEL_W(QSEL_W)
   ) u_dec (
      .addr(bus_addr), .hit(hit), .qsel(qsel), .reg_sel(reg_sel)
   );

   qpc_add_amt #(
      .DATA_W(DATA_W), .ADD_W(ADD_W), .PTR_W(PTR_W), .SATURATE(SATURATE_ADD)
   ) u_amt (
      .wdata(bus_wdata), .amt(amt)
   );

   generate
      for (genvar i = 0; i < NUM_Q; i++) begin : g_q
         logic sel_me;
         assign sel_me = bus_we && hit && (qsel == QSEL_W'(i));

         qpc_slot #(.PTR_W(PTR_W), .SIZE_RST(SIZE_RST)) u_slot (
            .clk(clk), .rst_n(rst_n),
            .add_rd_en(sel_me && (reg_sel == QREG_ADD_RD)),
            .add_wr_en(sel_me && (reg_sel == QREG_ADD_WR)),
            .size_en  (sel_me && (reg_sel == QREG_SIZE)),
            .amt(amt), .size_val(size_val),
            .rptr(q_rptr[i]), .wptr(q_wptr[i]), .size(q_size[i]),
            .occ(q_occ[i]), .ovf(q_ovf[i]), .unf(q_unf[i])
         );
      end
   endgenerate

   qpc_rdmux #(
      .NUM_Q(NUM_Q), .PTR_W(PTR_W), .DATA_W(DATA_W), .QSEL_W(QSEL_W)
   ) u_rmux (
      .hit(hit), .reg_sel(reg_sel), .qsel(qsel),
      .q_rptr(q_rptr), .q_wptr(q_wptr), .q_size(q_size), .q_occ(q_occ),
      .q_ovf(q_ovf), .q_unf(q_unf), .word(rd_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bus_rdata <= '0;
      else        bus_rdata <= bus_re ? rd_word : '0;
   end

endmodule

// File: rtl/qpc_checker.sv
module qpc_checker #(
   parameter int NUM_Q  = 8,
   parameter int PTR_W  = 18,
   parameter int ADD_W  = 6,
   parameter int DATA_W = 32
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        bus_we,
   input logic                        bus_re,
   input logic [DATA_W-1:0]           bus_rdata,
   input logic [NUM_Q-1:0][PTR_W-1:0] q_rptr,
   input logic [NUM_Q-1:0][PTR_W-1:0] q_wptr,
   input logic [NUM_Q-1:0]            q_ovf,
   input logic [NUM_Q-1:0]            q_unf
);
   localparam logic [PTR_W-1:0] MAX_STEP = PTR_W'((1 << ADD_W) - 1);

   // R9: no read strobe means zero data on the following cycle
   assert_idle_rdata_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_re |=> (bus_rdata == '0));

   generate
      for (genvar i = 0; i < NUM_Q; i++) begin : g_chk
         assert_rptr_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
            !bus_we |=> $stable(q_rptr[i]));
         assert_wptr_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
            !bus_we |=> $stable(q_wptr[i]));
         assert_wptr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
            bus_we |=> (PTR_W'(q_wptr[i] - $past(q_wptr[i])) <= MAX_STEP));
         assert_rptr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
            bus_we |=> (PTR_W'(q_rptr[i] - $past(q_rptr[i])) <= MAX_STEP));
         assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
            q_ovf[i] |=> q_ovf[i]);
         assert_ovf_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(q_ovf[i]) |-> $past(bus_we));
         assert_unf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
            q_unf[i] |=> q_unf[i]);
      end
   endgenerate

endmodule

bind qpc_top qpc_checker #(
   .NUM_Q(NUM_Q), .PTR_W(PTR_W), .ADD_W(ADD_W), .DATA_W(DATA_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
   .bus_rdata(bus_rdata), .q_rptr(q_rptr), .q_wptr(q_wptr),
   .q_ovf(q_ovf), .q_unf(q_unf)
);

// File: tb/sim_qpc_top.sv
module sim_qpc_top;
   localparam int CLK_PERIOD = 10;
   localparam int NQ = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [19:0] bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic        bus_re = 1'b0;
   logic [31:0] bus_rdata;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;

   // Expected state, kept from the requirements
   logic [17:0] m_r [NQ];
   logic [17:0] m_w [NQ];
   logic [17:0] m_sz[NQ];
   bit          m_of[NQ];
   bit          m_uf[NQ];

   always #(CLK_PERIOD/2) clk = ~clk;

   qpc_top #(.NUM_Q(NQ)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata)
   );

   function automatic logic [19:0] qa(input int q, input int off);
      return 20'h80000 + 20'(q) * 20'h800 + 20'(off);
   endfunction

   function automatic bit mapped(input logic [19:0] a);
      return a[19] && (int'(a[18:11]) < NQ);
   endfunction

   task automatic model_write(input logic [19:0] a, input logic [31:0] d);
      if (mapped(a)) begin
         int q = int'(a[18:11]);
         logic [17:0] n = {12'b0, d[5:0]};
         logic [17:0] occ = m_w[q] - m_r[q];
         case (a[10:0])
            11'h000: begin if (n > occ) m_uf[q] = 1'b1; m_r[q] = m_r[q] + n; end
            11'h004: begin if ({1'b0, occ} + {1'b0, n} > {1'b0, m_sz[q]}) m_of[q] = 1'b1;
                           m_w[q] = m_w[q] + n; end
            11'h010: m_sz[q] = d[17:0];
            default: ;
         endcase
      end
   endtask

   function automatic logic [31:0] expect_rd(input logic [19:0] a);
      if (!mapped(a)) return '0;
      begin
         int q = int'(a[18:11]);
         case (a[10:0])
            11'h008: return {m_uf[q], 13'b0, m_r[q]};
            11'h00C: return {m_of[q], 13'b0, m_w[q]};
            11'h010: return {14'b0, m_sz[q]};
            11'h014: return {14'b0, 18'(m_w[q] - m_r[q])};
            default: return '0;
         endcase
      end
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [19:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
      model_write(a, d);
   endtask

   task automatic bus_read(input logic [19:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_re = 1'b1;
      @(negedge clk);
      bus_re = 1'b0;
      d = bus_rdata;
   endtask

   task automatic chk_reg(input string req, input logic [19:0] a);
      logic [31:0] d;
      bus_read(a, d);
      chk(req, d, expect_rd(a));
   endtask

   task automatic t_reset_state();
      chk("R10 rdata after reset", bus_rdata, 32'h0);
      chk_reg("R10 q0 read ptr", qa(0, 'h08));
      chk_reg("R10 q0 write ptr", qa(0, 'h0C));
      chk("R10 q5 size", expect_rd(qa(5, 'h10)), 32'd64);
      chk_reg("R10 q5 size", qa(5, 'h10));
      chk_reg("R10 q7 occupancy", qa(7, 'h14));
   endtask

   task automatic t_basic_adds();
      bus_write(qa(1, 'h04), 32'd10);
      bus_write(qa(1, 'h04), 32'd20);
      bus_write(qa(1, 'h00), 32'd7);
      chk_reg("R1 q1 read ptr", qa(1, 'h08));
      chk_reg("R2 q1 write ptr", qa(1, 'h0C));
      chk_reg("R5 q1 occupancy", qa(1, 'h14));
      chk_reg("R1 q0 untouched by q1 adds", qa(0, 'h0C));
   endtask

   task automatic t_mask_add();
      bus_write(qa(2, 'h04), 32'h45);
      bus_write(qa(2, 'h04), 32'hFFFF_FFC1);
      chk("R3 masked sum", expect_rd(qa(2, 'h0C)), 32'd6);
      chk_reg("R3 q2 write ptr after wide adds", qa(2, 'h0C));
   endtask

   task automatic t_overflow();
      bus_write(qa(0, 'h04), 32'd63);
      bus_write(qa(0, 'h04), 32'd1);
      chk_reg("R6 occupancy equal to size, no overflow", qa(0, 'h0C));
      bus_write(qa(0, 'h04), 32'd1);
      chk("R6 model overflow", expect_rd(qa(0, 'h0C)), 32'h8000_0041);
      chk_reg("R6 overflow set, pointer advanced", qa(0, 'h0C));
   endtask

   task automatic t_underflow();
      bus_write(qa(0, 'h00), 32'd63);
      bus_write(qa(0, 'h00), 32'd2);
      chk_reg("R7 drain to zero, no underflow", qa(0, 'h08));
      bus_write(qa(0, 'h00), 32'd1);
      chk("R7 model underflow", expect_rd(qa(0, 'h08)), 32'h8000_0042);
      chk_reg("R7 underflow set, pointer advanced", qa(0, 'h08));
      chk_reg("R5 occupancy wraps below zero", qa(0, 'h14));
      bus_write(qa(0, 'h04), 32'd2);
      chk_reg("R6 overflow flag stays set", qa(0, 'h0C));
      chk_reg("R7 underflow flag stays set", qa(0, 'h08));
   endtask

   task automatic t_size_reg();
      bus_write(qa(3, 'h10), 32'hFFFC_0002);
      chk_reg("R5 size keeps low 18 bits", qa(3, 'h10));
      bus_write(qa(3, 'h04), 32'd3);
      chk_reg("R6 overflow against programmed size", qa(3, 'h0C));
   endtask

   task automatic t_wrap();
      for (int k = 0; k < 4161; k++) bus_write(qa(7, 'h04), 32'd63);
      chk_reg("R4 write ptr at top of range", qa(7, 'h0C));
      bus_write(qa(7, 'h04), 32'd1);
      chk("R4 model wrap", expect_rd(qa(7, 'h0C)), 32'h8000_0000);
      chk_reg("R4 write ptr wrapped to zero", qa(7, 'h0C));
      chk_reg("R4 occupancy after wrap", qa(7, 'h14));
   endtask

   task automatic t_unmapped();
      logic [31:0] d;
      bus_write(qa(8, 'h04), 32'd5);
      bus_read(qa(8, 'h0C), d);
      chk("R8 queue beyond NUM_Q reads zero", d, 32'h0);
      bus_write(20'h00004, 32'd7);
      bus_read(20'h0000C, d);
      chk("R8 below array reads zero", d, 32'h0);
      bus_write(qa(5, 'h06), 32'd9);
      bus_write(qa(5, 'h18), 32'd9);
      bus_read(qa(5, 'h18), d);
      chk("R8 unused offset reads zero", d, 32'h0);
      bus_read(qa(255, 'h08), d);
      chk("R8 queue 255 reads zero", d, 32'h0);
      chk_reg("R8 q5 write ptr untouched", qa(5, 'h0C));
      chk_reg("R8 q5 read ptr untouched", qa(5, 'h08));
      chk_reg("R8 q0 write ptr untouched", qa(0, 'h0C));
      bus_write(qa(6, 'h08), 32'd9);
      chk_reg("R8 write to status word ignored", qa(6, 'h08));
   endtask

   task automatic t_same_cycle();
      logic [31:0] d;
      @(negedge clk);
      bus_addr = qa(4, 'h10); bus_wdata = 32'd9; bus_we = 1'b1; bus_re = 1'b1;
      @(negedge clk);
      bus_we = 1'b0; bus_re = 1'b0;
      d = bus_rdata;
      chk("R9 read returns value before same-cycle write", d, 32'd64);
      model_write(qa(4, 'h10), 32'd9);
      chk_reg("R9 write took effect", qa(4, 'h10));
      @(negedge clk);
      chk("R9 rdata zero after idle cycle", bus_rdata, 32'h0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         n_checks++;
         $display("FAIL watchdog: actual hung, expected finished");
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   initial begin : main
      for (int q = 0; q < NQ; q++) begin
         m_r[q] = '0; m_w[q] = '0; m_sz[q] = 18'd64; m_of[q] = 1'b0; m_uf[q] = 1'b0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset_state();
      t_basic_adds();
      t_mask_add();
      t_overflow();
      t_underflow();
      t_size_reg();
      t_unmapped();
      t_same_cycle();
      t_wrap();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

endmodule